// File: doc/BRIEF.md
# Character glyph overlay renderer

This block lays a single 16x16 character glyph over a video pixel stream. On every pixel clock it receives the current horizontal and vertical pixel counters, the screen position of the glyph's top-left corner, a 7-bit character code and two 24-bit RGB colours (8 bits per channel). From these inputs it forms an address for an external synchronous glyph memory. Each word of that memory holds one 16-pixel row of one glyph. The block then picks the bit for the current pixel out of the returned word and drives either the foreground colour or the background colour.

The glyph memory returns data one clock after it samples the address. To cover this, the address is formed from the counters in the pixel's own cycle, and the column index and the inside-the-box flag are held for one cycle so that they meet the returned row word. As a result, the colour for a pixel appears one clock after that pixel's counters. Outside the glyph's 16x16 box the block drives the background colour. A synchronous reset clears the pipeline.

Top module: `glyph_overlay`

## Requirements
- R1: In the same cycle as its inputs, `glyph_addr` equals the character code in bits [10:4] and the low four bits of (v_count - org_y) in bits [3:0].
- R2: A pixel lies inside the glyph box only when both h_count - org_x and v_count - org_y are between 0 and 15. The subtraction does not wrap, so a counter smaller than its origin is outside the box.
- R3: The colour for the counters applied in cycle t appears on `pix_color` in cycle t+1. It is chosen using the row word that the memory returns for the address of cycle t.
- R4: Column c of the box, where c = h_count - org_x, uses bit 15-c of the row word. Bit 15 is therefore the leftmost dot.
- R5: Inside the box, a set bit gives `fg_color` and a clear bit gives `bg_color`, using the colour inputs present in the output cycle. `pix_color` never shows any value other than one of these two inputs.
- R6: A pixel outside the box gives `bg_color`, whatever the row word holds.
- R7: In the cycle after `rst` is sampled high, `pix_color` equals `bg_color`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Active-high synchronous reset |
| h_count | input | 13 | Horizontal pixel counter |
| v_count | input | 13 | Vertical pixel counter |
| org_x | input | 13 | Glyph box left edge |
| org_y | input | 13 | Glyph box top edge |
| char_code | input | 7 | Character to draw |
| fg_color | input | 24 | Foreground colour, 8-8-8 RGB |
| bg_color | input | 24 | Background colour, 8-8-8 RGB |
| glyph_addr | output | 11 | Address to the glyph memory |
| glyph_row | input | 16 | Row word from the glyph memory, one clock after the address |
| pix_color | output | 24 | Selected pixel colour |

## Verification
In any one cycle the block both issues the address for a new pixel and colours the previous pixel from the word that has just come back. The two events meet most sharply when the previous pixel was on the box edge and the new one is just outside it, or the other way round. The bench provokes this by sweeping the counters across a region larger than the box, with origins placed at 0, in the middle of the screen and at the top of the counter range. It also changes the colours and asserts reset while the sweep is inside the box. A behavioural model compares both `glyph_addr` for the current pixel and `pix_color` for the previous pixel on every clock.

// File: rtl/glyph_pkg.sv
package glyph_pkg;
  localparam int COORD_W = 13;
  localparam int GLYPH_W = 16;
  localparam int IDX_W   = $clog2(GLYPH_W);
  localparam int CODE_W  = 7;
  localparam int COLOR_W = 24;
  localparam int ADDR_W  = CODE_W + IDX_W;

  // Difference between position and origin, one bit wider so negatives are large.
  function automatic logic [COORD_W:0] span_offset(input logic [COORD_W-1:0] pos,
                                                   input logic [COORD_W-1:0] org);
    return {1'b0, pos} - {1'b0, org};
  endfunction

  function automatic logic within_glyph(input logic [COORD_W:0] d);
    return d < (COORD_W+1)'(GLYPH_W);
  endfunction

  function automatic logic [ADDR_W-1:0] make_addr(input logic [CODE_W-1:0] code,
                                                  input logic [IDX_W-1:0] row);
    return {code, row};
  endfunction

  // Column 0 is the most significant bit of the row word.
  function automatic logic pick_bit(input logic [GLYPH_W-1:0] word,
                                    input logic [IDX_W-1:0] col);
    logic [IDX_W-1:0] flip;
    flip = IDX_W'(GLYPH_W - 1) - col;
    return word[flip];
  endfunction
endpackage

// File: rtl/glyph_locator.sv
module glyph_locator
  import glyph_pkg::*;
(
  input  logic [COORD_W-1:0] h_count,
  input  logic [COORD_W-1:0] v_count,
  input  logic [COORD_W-1:0] org_x,
  input  logic [COORD_W-1:0] org_y,
  input  logic [CODE_W-1:0]  char_code,
  output logic [IDX_W-1:0]   col_idx,
  output logic               in_box,
  output logic [ADDR_W-1:0]  glyph_addr
);
  logic [COORD_W:0] dx, dy;

  always_comb begin
    dx         = span_offset(h_count, org_x);
    dy         = span_offset(v_count, org_y);
    in_box     = within_glyph(dx) && within_glyph(dy);
    col_idx    = dx[IDX_W-1:0];
    glyph_addr = make_addr(char_code, dy[IDX_W-1:0]);
  end
endmodule

// File: rtl/glyph_align.sv
module glyph_align
  import glyph_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] col_idx,
  input  logic             in_box,
  output logic [IDX_W-1:0] col_q,
  output logic             in_box_q
);
  // Matches the one-cycle read latency of the glyph memory.
  always_ff @(posedge clk) begin
    if (rst) begin
      col_q    <= '0;
      in_box_q <= 1'b0;
    end else begin
      col_q    <= col_idx;
      in_box_q <= in_box;
    end
  end
endmodule

// File: rtl/glyph_pixel_mux.sv
module glyph_pixel_mux
  import glyph_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [GLYPH_W-1:0] glyph_row,
  input  logic [IDX_W-1:0]   col_q,
  input  logic               in_box_q,
  input  logic [COLOR_W-1:0] fg_color,
  input  logic [COLOR_W-1:0] bg_color,
  output logic               dot_on,
  output logic [COLOR_W-1:0] pix_color
);
  always_comb begin
    dot_on    = in_box_q && pick_bit(glyph_row, col_q);
    pix_color = dot_on ? fg_color : bg_color;
  end

  // R6: no glyph dot is shown for a pixel outside the box
  p_outside_bg_r6: assert property (@(posedge clk) disable iff (rst)
    !in_box_q |-> pix_color == bg_color);

  // R5: only one of the two colour inputs can reach the output
  p_output_choice_r5: assert property (@(posedge clk) disable iff (rst)
    (pix_color == fg_color) || (pix_color == bg_color));
endmodule

// File: rtl/glyph_overlay.sv
module glyph_overlay
  import glyph_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [12:0]        h_count,
  input  logic [12:0]        v_count,
  input  logic [12:0]        org_x,
  input  logic [12:0]        org_y,
  input  logic [6:0]         char_code,
  input  logic [23:0]        fg_color,
  input  logic [23:0]        bg_color,
  output logic [10:0]        glyph_addr,
  input  logic [15:0]        glyph_row,
  output logic [23:0]        pix_color
);
  logic [IDX_W-1:0] col_idx, col_q;
  logic             in_box, in_box_q, dot_on;

  glyph_locator u_loc (
    .h_count(h_count), .v_count(v_count), .org_x(org_x), .org_y(org_y),
    .char_code(char_code), .col_idx(col_idx), .in_box(in_box),
    .glyph_addr(glyph_addr)
  );

  glyph_align u_align (
    .clk(clk), .rst(rst), .col_idx(col_idx), .in_box(in_box),
    .col_q(col_q), .in_box_q(in_box_q)
  );

  glyph_pixel_mux u_mux (
    .clk(clk), .rst(rst), .glyph_row(glyph_row), .col_q(col_q),
    .in_box_q(in_box_q), .fg_color(fg_color), .bg_color(bg_color),
    .dot_on(dot_on), .pix_color(pix_color)
  );

  // R2: the box flag never rises for a counter below its origin
  p_inbox_bounds_r2: assert property (@(posedge clk) disable iff (rst)
    in_box |-> (h_count >= org_x) && (v_count >= org_y));

  // R3: a dot shown now needs an in-box pixel one cycle earlier
  p_dot_needs_box_r3: assert property (@(posedge clk) disable iff (rst)
    dot_on |-> $past(in_box));

  // R7: the cycle after reset is sampled shows background
  p_reset_bg_r7: assert property (@(posedge clk)
    rst |=> pix_color == bg_color);
endmodule

// File: tb/glyph_overlay_tb_top.sv
`timescale 1ns/1ps
module glyph_overlay_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [12:0] h_count = '0, v_count = '0, org_x = '0, org_y = '0;
  logic [6:0]  char_code = '0;
  logic [23:0] fg_color = 24'hFF0000, bg_color = 24'h00FF00;
  logic [10:0] glyph_addr;
  logic [15:0] glyph_row;
  logic [23:0] pix_color;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  glyph_overlay dut_i (
    .clk(clk), .rst(rst), .h_count(h_count), .v_count(v_count),
    .org_x(org_x), .org_y(org_y), .char_code(char_code),
    .fg_color(fg_color), .bg_color(bg_color), .glyph_addr(glyph_addr),
    .glyph_row(glyph_row), .pix_color(pix_color)
  );

  // Behavioural glyph store: code 0 blank, code 127 solid, others a hash.
  function automatic logic [15:0] glyph(input int code, input int row);
    if (code == 0) return 16'h0000;
    if (code == 127) return 16'hFFFF;
    return 16'((code * 40503) ^ (row * 4661) ^ (row << 11));
  endfunction

  always_ff @(posedge clk) glyph_row <= glyph(int'(glyph_addr[10:4]), int'(glyph_addr[3:0]));

  // Model state for the pixel presented in the previous cycle.
  bit p_valid = 0, p_rst = 1, p_box = 0;
  int p_code = 0, p_row = 0, p_col = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int h, input int v, input bit r);
    int dx, dy;
    logic [23:0] exp;
    @(negedge clk);
    if (p_valid) begin
      if (p_rst) exp = bg_color;                          // R7
      else if (p_box && glyph(p_code, p_row)[15 - p_col]) exp = fg_color; // R4 R5
      else exp = bg_color;                                // R6
      check("R3/R4/R5/R6/R7 pix_color", 32'(pix_color), 32'(exp));
    end
    rst = r; h_count = 13'(h); v_count = 13'(v);
    #1;
    dx = h - int'(org_x); dy = v - int'(org_y);
    check("R1 glyph_addr", 32'(glyph_addr),
          32'({char_code, 4'(dy & 15)}));
    p_valid = 1; p_rst = r;
    p_box = (dx >= 0 && dx < 16 && dy >= 0 && dy < 16);   // R2
    p_code = int'(char_code); p_row = dy & 15; p_col = dx & 15;
  endtask

  task automatic sweep(input int x0, input int y0, input int w, input int hgt);
    for (int y = y0; y < y0 + hgt; y++)
      for (int x = x0; x < x0 + w; x++)
        if (x >= 0 && x < 8192 && y >= 0 && y < 8192) step(x, y, 0);
  endtask

  initial begin
    org_x = 13'd192; org_y = 13'd41; char_code = 7'h30;
    step(0, 0, 1); step(0, 0, 1); step(195, 44, 1);       // R7 reset state
    step(195, 44, 0);
    sweep(190, 39, 20, 20);                               // R2 R3 R4 R5 mid-screen
    char_code = 7'd127; sweep(189, 40, 21, 3);            // solid glyph edges
    char_code = 7'd0;   sweep(191, 45, 18, 2);            // blank glyph
    org_x = 13'd5; org_y = 13'd0; char_code = 7'h41;      // R2 no wrap below origin
    sweep(0, 0, 24, 17);
    org_x = 13'd8178; org_y = 13'd8178; char_code = 7'h7E; // top of counter range
    sweep(8176, 8176, 16, 16);
    org_x = 13'd100; org_y = 13'd100; char_code = 7'd127;
    for (int i = 0; i < 8; i++) begin                     // R5 colour change mid-box
      fg_color = 24'(32'h123456 * (i + 1)); bg_color = ~fg_color;
      step(100 + i, 100 + i, 0);
    end
    step(104, 104, 1); step(105, 104, 1);                 // R7 reset inside box
    step(106, 104, 0); step(107, 104, 0); step(200, 200, 0);
    step(200, 200, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule